// File: doc/BRIEF.md
# Two-Level Trap Delegation Unit

This block holds the machine-level and hypervisor-level delegation registers for exceptions and interrupts. For each trap it reports which privilege mode takes it: machine mode (M), the hypervisor-extended supervisor mode (HS) or the virtual supervisor mode (VS).

Software reaches the registers through a simple CSR port. The port has an address, write data and a write enable. Read data and an illegal-address flag are combinational on the address.

The trap side takes the following inputs and gives the target mode in the same cycle:
- a valid strobe;
- an interrupt/exception flag;
- a 6-bit cause;
- the current privilege;
- the virtualization flag.

Both exception delegation registers are 64 bits wide for either XLEN. With XLEN=32 the upper half of each is reached through its own alias address. The interrupt delegation registers are XLEN bits wide.

A trap is first tested against the machine-level register. If the machine-level register delegates it and the hart was virtualized, it is then tested against the hypervisor-level register.

Top module: `trap_deleg_unit`

## Requirements
- R1: After reset every delegation register reads as zero, so every valid trap resolves to M (target code 2'b11).
- R2: The machine exception delegation register is 64 bits wide.
  - With XLEN=64, address 0x302 reads and writes all 64 bits.
  - With XLEN=32, address 0x302 reaches bits 31:0, and address 0x312 reaches bits 63:32.
- R3: The hypervisor exception delegation register is 64 bits wide.
  - With XLEN=64, address 0x602 reads and writes all 64 bits.
  - With XLEN=32, address 0x602 reaches bits 31:0, and address 0x612 reaches bits 63:32.
- R4: `csr_illegal` is 1 for any address that does not exist. This includes 0x312 and 0x612 when XLEN=64. An access to such an address reads 0 and a write to it changes no register.
- R5: Every register keeps only its writable bits, and all other bits read 0. The default writable masks are:
  - machine exception register: 0x0000_00FF_0000_B3FF;
  - hypervisor exception register: 0x0000_00FF_0000_B1FF;
  - machine interrupt register: 0x666;
  - hypervisor interrupt register: bits 10, 6 and 2 only (0x444).
- R6: The machine interrupt delegation register is at 0x303 and the hypervisor interrupt delegation register is at 0x603. Both are XLEN bits wide.
- R7: The delegation bit used for a trap is the bit whose index equals the cause. Exceptions use the exception registers and interrupts use the interrupt registers. If the machine-level bit is clear, the target is M.
- R8: A trap taken while the current privilege is M (2'b11) always targets M.
- R9: A trap delegated by the machine level targets VS (2'b10) only when `cur_virt` is 1 and the hypervisor-level bit is set. Otherwise it targets HS (2'b01).
- R10: A CSR write takes effect at the next clock edge. A trap resolved in the same cycle as the write uses the old register values.
- R11: While `trap_valid` is 0, `trap_target` shows M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_rdata | output | XLEN | CSR read data for `csr_addr` |
| csr_illegal | output | 1 | Address is not implemented |
| trap_valid | input | 1 | Trap present this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 6 | Cause code |
| cur_priv | input | 2 | Current privilege (3 = M, 1 = S, 0 = U) |
| cur_virt | input | 1 | Hart is virtualized (VS or VU) |
| trap_target | output | 2 | Target mode: 3 = M, 1 = HS, 2 = VS |

## Verification
A corrupted delegation bit shows in two places in the same cycle. The first is the read data of its CSR address. The second is the target of any trap whose cause indexes that bit, which lands in the wrong mode with no delay.

A bad alias decode with XLEN=32 can leave one half of a 64-bit register unreachable or overwrite the wrong half. This shows on the next read of either half.

A bench that runs an XLEN=64 and an XLEN=32 instance side by side, reading back after every write, catches either fault within one cycle of its cause.

// File: rtl/trap_deleg_unit.sv
module trap_deleg_unit #(
  parameter int          XLEN          = 64,
  parameter logic [63:0] MEDELEG_WMASK = 64'h0000_00FF_0000_B3FF,
  parameter logic [63:0] HEDELEG_WMASK = 64'h0000_00FF_0000_B1FF,
  parameter logic [63:0] MIDELEG_WMASK = 64'h0000_0000_0000_0666,
  parameter logic [63:0] HIDELEG_WMASK = 64'h0000_0000_0000_0444
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic            trap_valid,
  input  logic            trap_is_irq,
  input  logic [5:0]      trap_cause,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  output logic [1:0]      trap_target
);

  localparam bit          NARROW = (XLEN == 32);
  localparam logic [63:0] XMASK  = NARROW ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MID_M  = MIDELEG_WMASK & XMASK;
  localparam logic [63:0] HID_M  = HIDELEG_WMASK & XMASK;

  localparam logic [11:0] A_MED  = 12'h302;
  localparam logic [11:0] A_MID  = 12'h303;
  localparam logic [11:0] A_MEDH = 12'h312;
  localparam logic [11:0] A_HED  = 12'h602;
  localparam logic [11:0] A_HID  = 12'h603;
  localparam logic [11:0] A_HEDH = 12'h612;

  localparam logic [1:0] MODE_M  = 2'b11;
  localparam logic [1:0] MODE_HS = 2'b01;
  localparam logic [1:0] MODE_VS = 2'b10;

  logic [63:0] med_q, hed_q, mid_q, hid_q;
  logic [63:0] wd, rd, med_wr, hed_wr;
  logic sel_med, sel_medh, sel_mid, sel_hed, sel_hedh, sel_hid;
  logic m_bit, h_bit;

  assign wd = 64'(csr_wdata);

  assign sel_med  = (csr_addr == A_MED);
  assign sel_mid  = (csr_addr == A_MID);
  assign sel_hed  = (csr_addr == A_HED);
  assign sel_hid  = (csr_addr == A_HID);
  assign sel_medh = NARROW && (csr_addr == A_MEDH);
  assign sel_hedh = NARROW && (csr_addr == A_HEDH);

  assign csr_illegal = !(sel_med | sel_medh | sel_mid | sel_hed | sel_hedh | sel_hid);

  assign med_wr = !NARROW ? wd :
                  sel_medh ? {wd[31:0], med_q[31:0]} : {med_q[63:32], wd[31:0]};
  assign hed_wr = !NARROW ? wd :
                  sel_hedh ? {wd[31:0], hed_q[31:0]} : {hed_q[63:32], wd[31:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      med_q <= '0;
      hed_q <= '0;
      mid_q <= '0;
      hid_q <= '0;
    end else if (csr_we) begin
      if (sel_med || sel_medh) med_q <= med_wr & MEDELEG_WMASK;
      if (sel_hed || sel_hedh) hed_q <= hed_wr & HEDELEG_WMASK;
      if (sel_mid)             mid_q <= wd & MID_M;
      if (sel_hid)             hid_q <= wd & HID_M;
    end
  end

  always_comb begin
    rd = '0;
    if (sel_med)       rd = med_q;
    else if (sel_medh) rd = {32'b0, med_q[63:32]};
    else if (sel_mid)  rd = mid_q;
    else if (sel_hed)  rd = hed_q;
    else if (sel_hedh) rd = {32'b0, hed_q[63:32]};
    else if (sel_hid)  rd = hid_q;
  end

  assign csr_rdata = rd[XLEN-1:0];

  assign m_bit = trap_is_irq ? mid_q[trap_cause] : med_q[trap_cause];
  assign h_bit = trap_is_irq ? hid_q[trap_cause] : hed_q[trap_cause];

  always_comb begin
    trap_target = MODE_M;
    if (trap_valid && cur_priv != MODE_M && m_bit)
      trap_target = (cur_virt && h_bit) ? MODE_VS : MODE_HS;
  end

  AST_MPRIV_STAYS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == MODE_M) |-> trap_target == MODE_M); // R8
  AST_NO_VS_UNVIRT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !cur_virt) |-> trap_target != MODE_VS); // R9
  AST_IDLE_IS_M: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> trap_target == MODE_M); // R11
  AST_ALIAS_ABSENT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!NARROW && (csr_addr == A_MEDH || csr_addr == A_HEDH)) |-> csr_illegal); // R4
  AST_HID_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_HID) |-> (csr_rdata & ~HID_M[XLEN-1:0]) == '0); // R5
  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0); // R4

endmodule

// File: tb/trap_deleg_unit_tb.sv
`timescale 1ns/1ps
module trap_deleg_unit_tb;
  localparam logic [63:0] MED_M = 64'h0000_00FF_0000_B3FF;
  localparam logic [63:0] HED_M = 64'h0000_00FF_0000_B1FF;
  localparam logic [63:0] MID_M = 64'h666;
  localparam logic [63:0] HID_M = 64'h444;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] csr_addr = '0;
  logic [63:0] wdata = '0;
  logic        csr_we = 0;
  logic        trap_valid = 0, trap_is_irq = 0, cur_virt = 0;
  logic [5:0]  trap_cause = '0;
  logic [1:0]  cur_priv = 2'b00;
  logic [63:0] rdata64;
  logic [31:0] rdata32;
  logic        ill64, ill32;
  logic [1:0]  tgt64, tgt32;

  int checks = 0, errors = 0;
  logic [63:0] mde [2], hde [2], mid [2], hid [2];

  always #2 clk = ~clk;

  trap_deleg_unit #(.XLEN(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(wdata), .csr_we(csr_we),
    .csr_rdata(rdata64), .csr_illegal(ill64), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
    .trap_cause(trap_cause), .cur_priv(cur_priv), .cur_virt(cur_virt), .trap_target(tgt64));

  trap_deleg_unit #(.XLEN(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(wdata[31:0]), .csr_we(csr_we),
    .csr_rdata(rdata32), .csr_illegal(ill32), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
    .trap_cause(trap_cause), .cur_priv(cur_priv), .cur_virt(cur_virt), .trap_target(tgt32));

  function automatic bit exp_illegal(int k, logic [11:0] a);
    if (a == 12'h302 || a == 12'h303 || a == 12'h602 || a == 12'h603) return 0;
    if (k == 1 && (a == 12'h312 || a == 12'h612)) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] exp_read(int k, logic [11:0] a);
    if (exp_illegal(k, a)) return '0;
    case (a)
      12'h302: return mde[k];
      12'h312: return {32'b0, mde[k][63:32]};
      12'h303: return mid[k];
      12'h602: return hde[k];
      12'h612: return {32'b0, hde[k][63:32]};
      12'h603: return hid[k];
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] exp_target(int k, logic tv, logic irq, logic [5:0] c,
                                            logic [1:0] p, logic v);
    logic mb, hb;
    if (!tv || p == 2'b11) return 2'b11;
    mb = irq ? mid[k][c] : mde[k][c];
    hb = irq ? hid[k][c] : hde[k][c];
    if (!mb) return 2'b11;
    return (v && hb) ? 2'b10 : 2'b01;
  endfunction

  function automatic string req_of(logic [11:0] a);
    case (a)
      12'h302, 12'h312: return "R2";
      12'h602, 12'h612: return "R3";
      12'h303, 12'h603: return "R6";
      default:          return "R4";
    endcase
  endfunction

  task automatic model_write(logic [11:0] a, logic [63:0] d);
    for (int k = 0; k < 2; k++) begin
      logic [63:0] xm;
      xm = (k == 1) ? 64'hFFFF_FFFF : '1;
      if (!exp_illegal(k, a)) begin
        case (a)
          12'h302: mde[k] = ((k == 1) ? {mde[k][63:32], d[31:0]} : d) & MED_M;
          12'h312: mde[k] = {d[31:0], mde[k][31:0]} & MED_M;
          12'h602: hde[k] = ((k == 1) ? {hde[k][63:32], d[31:0]} : d) & HED_M;
          12'h612: hde[k] = {d[31:0], hde[k][31:0]} & HED_M;
          12'h303: mid[k] = d & MID_M & xm;
          12'h603: hid[k] = d & HID_M & xm;
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic we, logic [11:0] a, logic [63:0] d, logic tv, logic irq,
                      logic [5:0] c, logic [1:0] p, logic v, string rtag, string ttag);
    logic [63:0] e;
    @(negedge clk);
    csr_we = we; csr_addr = a; wdata = d;
    trap_valid = tv; trap_is_irq = irq; trap_cause = c; cur_priv = p; cur_virt = v;
    #1;
    e = exp_read(0, a);
    chk(rdata64 == e, rtag, "rdata64", rdata64, e);
    e = exp_read(1, a);
    chk(rdata32 == e[31:0], rtag, "rdata32", {32'b0, rdata32}, e);
    chk(ill64 == exp_illegal(0, a), "R4", "illegal64", {63'b0, ill64}, {63'b0, exp_illegal(0, a)});
    chk(ill32 == exp_illegal(1, a), "R4", "illegal32", {63'b0, ill32}, {63'b0, exp_illegal(1, a)});
    e = {62'b0, exp_target(0, tv, irq, c, p, v)};
    chk(tgt64 == e[1:0], ttag, "target64", {62'b0, tgt64}, e);
    e = {62'b0, exp_target(1, tv, irq, c, p, v)};
    chk(tgt32 == e[1:0], ttag, "target32", {62'b0, tgt32}, e);
    @(posedge clk);
    if (we) model_write(a, d);
  endtask

  logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  logic [11:0] addr_list [8] = '{12'h302, 12'h312, 12'h303, 12'h602, 12'h612, 12'h603, 12'h7C0, 12'h301};
  bit done = 0;

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int k = 0; k < 2; k++) begin mde[k] = 0; hde[k] = 0; mid[k] = 0; hid[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    foreach (addr_list[i]) step(0, addr_list[i], 0, 1, 0, 6'd8, 2'b00, 1, "R1", "R1");
    step(0, 12'h302, 0, 1, 1, 6'd6, 2'b01, 1, "R1", "R1");

    step(1, 12'h302, ONES, 0, 0, 0, 0, 0, "R2", "R11");
    step(0, 12'h302, 0, 0, 0, 0, 0, 0, "R5", "R11");
    step(1, 12'h312, ONES, 0, 0, 0, 0, 0, "R4", "R11");
    step(0, 12'h312, 0, 0, 0, 0, 0, 0, "R2", "R11");
    step(1, 12'h602, ONES, 0, 0, 0, 0, 0, "R3", "R11");
    step(1, 12'h612, ONES, 0, 0, 0, 0, 0, "R3", "R11");
    step(0, 12'h612, 0, 0, 0, 0, 0, 0, "R3", "R11");
    step(1, 12'h303, ONES, 0, 0, 0, 0, 0, "R6", "R11");
    step(1, 12'h603, ONES, 0, 0, 0, 0, 0, "R6", "R11");
    step(0, 12'h603, 0, 0, 0, 0, 0, 0, "R5", "R11");
    step(0, 12'h303, 0, 0, 0, 0, 0, 0, "R5", "R11");

    step(0, 12'h302, 0, 1, 0, 6'd8,  2'b00, 1, "R2", "R9");
    step(0, 12'h302, 0, 1, 0, 6'd8,  2'b00, 0, "R2", "R9");
    step(0, 12'h302, 0, 1, 0, 6'd9,  2'b00, 1, "R2", "R9");
    step(0, 12'h302, 0, 1, 0, 6'd8,  2'b11, 1, "R2", "R8");
    step(0, 12'h302, 0, 1, 0, 6'd11, 2'b00, 1, "R2", "R7");
    step(0, 12'h302, 0, 1, 0, 6'd35, 2'b01, 1, "R2", "R7");
    step(0, 12'h302, 0, 1, 1, 6'd6,  2'b00, 1, "R2", "R9");
    step(0, 12'h302, 0, 1, 1, 6'd5,  2'b00, 1, "R2", "R9");
    step(0, 12'h302, 0, 1, 1, 6'd7,  2'b01, 0, "R2", "R7");
    step(0, 12'h302, 0, 0, 1, 6'd6,  2'b00, 1, "R2", "R11");

    step(1, 12'h302, 0, 1, 0, 6'd8, 2'b00, 1, "R10", "R10");
    step(0, 12'h302, 0, 1, 0, 6'd8, 2'b00, 1, "R10", "R10");
    step(1, 12'h312, 64'h0000_0000_0000_000F, 1, 0, 6'd33, 2'b00, 1, "R10", "R10");
    step(0, 12'h302, 0, 1, 0, 6'd33, 2'b00, 1, "R10", "R10");

    for (int i = 0; i < 2000; i++) begin
      logic [11:0] a;
      logic [63:0] d;
      a = addr_list[$urandom_range(7, 0)];
      d = {$urandom, $urandom};
      step($urandom_range(1, 0), a, d, $urandom_range(3, 0) != 0, $urandom_range(1, 0),
           6'($urandom_range(63, 0)), 2'($urandom_range(3, 0)), $urandom_range(1, 0),
           req_of(a), "R7/R8/R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule